// File: doc/BRIEF.md
# Open-Drain I2C Register Master

This block talks to a single clock-generator chip over a two-wire I2C bus. The data line is open-drain. The block never drives it high. It only switches an output-enable that pulls the line low, while the line's output value is tied to zero. The clock line is driven both ways. All bus timing comes from a half-period counter clocked by the system clock. Every change on the pins starts on a half-period boundary.

A host issues one of three commands through a valid/ready request port:
- **Bus-recovery init:** checks that the data line is free. If it is held low, the block clocks SCL to release it.
- **Single-register write:** start, address with write bit, register byte, value byte, stop.
- **Single-register read:** a write of the register byte closed by a stop, then a fresh start, the address with the read bit, one data byte answered with no-acknowledge, and a stop.

Back-pressure rules: `req_ready` is high only while the block is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. While a command runs, `req_ready` stays low and the request port is ignored, so the host must hold its request until `req_ready` returns. At the end of a command, `done` pulses for one cycle. The error flags and `rd_data` are valid from that cycle on.

Top module: `od_i2c_reg_master`

## Requirements
- R1: After reset and whenever idle, `scl_o`=1, `sda_oe`=0, `req_ready`=1, `done`=0. After reset, `rd_data` and all error flags are 0.
- R2: A request is accepted on an edge with `req_valid`=1 and `req_ready`=1. `req_ready` is 0 from the next cycle until the cycle `done` is 1. Requests presented while busy have no effect on the bus.
- R3: Pin timing is slot-based. Slot i drives its pin values starting at the edge that lies i·HALF_CYCLES edges after the accept edge. The pins change only at such edges. Inputs are sampled at the edge that ends a slot.
- R4: A start is the slot pair (SCL,OE)=(1,0),(1,1). A stop is the three slots (0,1),(1,1),(1,0).
- R5: A written byte goes MSB first as 8 slot pairs (0,~b),(1,~b), where OE=1 means the line is pulled to 0. OE changes only while SCL is low.
- R6: After each written byte come the ack slots (0,0),(1,0). The byte counts as acknowledged if the line reads 0 at the end of the high slot.
- R7: Write command (`req_op`=1): start, byte {TARGET_ADDR,0}, the register byte, the value byte (each followed by its ack slots), then stop. It finishes with no error flag set.
- R8: Read command (`req_op`=2 or 3):
  - Bus sequence: start, {TARGET_ADDR,0}, register, stop; then start, {TARGET_ADDR,1}; then one slot (0,0); then 8 pairs (0,0),(1,0), each bit sampled MSB first at the end of its high slot; then the no-ack pair (0,0),(1,0); then stop.
  - Result: the byte read appears on `rd_data` in the `done` cycle.
- R9: A missing ack ends the command right after that ack slot, with no stop. `done` pulses with `err_nack`=1 and `err_phase` telling which byte failed: 0 = address for write, 1 = register, 2 = value, 3 = address for read.
- R10: Init command (`req_op`=0):
  - The block releases the line for two slots with SCL high.
  - If the line then reads 1, it finishes with no error.
  - Otherwise it runs 8 pairs (0,0),(1,0). If the line still reads 0 at the end of the last high slot, it sets `err_stuck`.
- R11: `rd_data` changes only when a read command completes without error.
- R12: `done` is high for exactly one cycle per command. The error flags hold from `done` until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 2 | 0 init, 1 write, 2 or 3 read |
| req_reg | input | 8 | Register address on the target |
| req_wdata | input | 8 | Value for a write |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Last successfully read byte |
| err_nack | output | 1 | A byte was not acknowledged |
| err_phase | output | 2 | Which byte failed to be acknowledged |
| err_stuck | output | 1 | Data line still low after recovery clocking |
| scl_o | output | 1 | Clock line drive |
| sda_oe | output | 1 | Pull data line low when 1 |
| sda_i | input | 1 | Sensed data line level |

## Verification
The bench models the target chip and aims at these corner cases:
- **No-ack in each of the four byte positions.** A design that ignores the ack would carry on clocking bytes. One that mislabels the phase would report the wrong code.
- **Stuck data line.** Init is run with the line held low once and with it held low forever. A design that skips recovery, or samples too early, would report the wrong error state.
- **Read data patterns.** Reads return all-zeros, all-ones and mixed bytes. Failed reads and writes follow them, so a design that updates the read register on an abort, or shifts bits in the wrong order, shows a wrong `rd_data`.
- **Requests while busy.** Junk requests presented mid-command must leave the bus sequence untouched.

// File: rtl/od_i2c_pkg.sv
package od_i2c_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_CHK, S_RCV, S_STA, S_WB, S_WACK, S_STP, S_RPR, S_RB, S_RNK
  } seq_st_t;

  typedef enum logic [1:0] {
    PH_ADDR_W = 2'd0,
    PH_REG    = 2'd1,
    PH_VAL    = 2'd2,
    PH_ADDR_R = 2'd3
  } byte_ph_t;

endpackage

// File: rtl/od_i2c_halftick.sv
module od_i2c_halftick #(
  parameter int HALF_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = $clog2(HALF_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt <= '0;
    else if (run) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);

  // R3: slot boundaries are at least two cycles apart
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/od_i2c_pin_decode.sv
module od_i2c_pin_decode
  import od_i2c_pkg::*;
(
  input  seq_st_t    st,
  input  logic       hi,
  input  logic [2:0] bitn,
  input  logic       msb,
  output logic       scl,
  output logic       oe
);
  always_comb begin
    scl = 1'b1;
    oe  = 1'b0;
    case (st)
      S_RCV, S_WACK, S_RB, S_RNK: scl = hi;
      S_STA:                      oe  = hi;
      S_WB: begin scl = hi; oe = !msb; end
      S_STP: begin scl = (bitn != 3'd0); oe = (bitn != 3'd2); end
      S_RPR:                      scl = 1'b0;
      default: ;
    endcase
  end
endmodule

// File: rtl/od_i2c_reg_master.sv
module od_i2c_reg_master
  import od_i2c_pkg::*;
#(
  parameter int         HALF_CYCLES = 16,
  parameter logic [6:0] TARGET_ADDR = 7'h67
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [1:0] req_op,
  input  logic [7:0] req_reg,
  input  logic [7:0] req_wdata,
  output logic       done,
  output logic [7:0] rd_data,
  output logic       err_nack,
  output logic [1:0] err_phase,
  output logic       err_stuck,
  output logic       scl_o,
  output logic       sda_oe,
  input  logic       sda_i
);
  localparam int SYNC_STAGES = 2;

  seq_st_t    st, st_d;
  byte_ph_t   stage, stage_d;
  logic       hi, hi_d;
  logic [2:0] bitn, bitn_d;
  logic [7:0] sh, sh_d;
  logic [7:0] reg_q, wdata_q;
  logic       is_rd;
  logic       accept, tick, fin, nk, stk;
  logic       scl_d, oe_d, sda_s;
  logic [SYNC_STAGES-1:0] sync_q;

  assign req_ready = (st == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign sda_s     = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], sda_i};
  end

  od_i2c_halftick #(.HALF_CYCLES(HALF_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(accept),
    .run(st != S_IDLE), .tick(tick)
  );

  always_comb begin
    st_d = st; stage_d = stage; hi_d = hi; bitn_d = bitn; sh_d = sh;
    fin = 1'b0; nk = 1'b0; stk = 1'b0;
    if (st == S_IDLE) begin
      if (accept) begin
        hi_d = 1'b0; bitn_d = '0;
        if (req_op == 2'd0) st_d = S_CHK;
        else begin
          st_d = S_STA; sh_d = {TARGET_ADDR, 1'b0}; stage_d = PH_ADDR_W;
        end
      end
    end else if (tick) begin
      case (st)
        S_CHK:
          if (!hi) hi_d = 1'b1;
          else if (sda_s) fin = 1'b1;
          else begin st_d = S_RCV; hi_d = 1'b0; bitn_d = '0; end
        S_RCV:
          if (!hi) hi_d = 1'b1;
          else begin
            hi_d = 1'b0;
            if (bitn == 3'd7) begin fin = 1'b1; stk = !sda_s; end
            else bitn_d = bitn + 3'd1;
          end
        S_STA:
          if (!hi) hi_d = 1'b1;
          else begin st_d = S_WB; hi_d = 1'b0; bitn_d = '0; end
        S_WB:
          if (!hi) hi_d = 1'b1;
          else begin
            hi_d = 1'b0; sh_d = {sh[6:0], 1'b0};
            if (bitn == 3'd7) st_d = S_WACK;
            else bitn_d = bitn + 3'd1;
          end
        S_WACK:
          if (!hi) hi_d = 1'b1;
          else begin
            hi_d = 1'b0; bitn_d = '0;
            if (sda_s) begin fin = 1'b1; nk = 1'b1; end
            else begin
              case (stage)
                PH_ADDR_W: begin stage_d = PH_REG; sh_d = reg_q; st_d = S_WB; end
                PH_REG:
                  if (is_rd) st_d = S_STP;
                  else begin stage_d = PH_VAL; sh_d = wdata_q; st_d = S_WB; end
                PH_VAL:    st_d = S_STP;
                PH_ADDR_R: st_d = S_RPR;
                default:   st_d = S_STP;
              endcase
            end
          end
        S_STP:
          if (bitn != 3'd2) bitn_d = bitn + 3'd1;
          else if (is_rd && stage == PH_REG) begin
            st_d = S_STA; hi_d = 1'b0; bitn_d = '0;
            stage_d = PH_ADDR_R; sh_d = {TARGET_ADDR, 1'b1};
          end else fin = 1'b1;
        S_RPR: begin st_d = S_RB; hi_d = 1'b0; bitn_d = '0; end
        S_RB:
          if (!hi) hi_d = 1'b1;
          else begin
            hi_d = 1'b0; sh_d = {sh[6:0], sda_s};
            if (bitn == 3'd7) st_d = S_RNK;
            else bitn_d = bitn + 3'd1;
          end
        S_RNK:
          if (!hi) hi_d = 1'b1;
          else begin hi_d = 1'b0; bitn_d = '0; st_d = S_STP; end
        default: fin = 1'b1;
      endcase
      if (fin) st_d = S_IDLE;
    end
  end

  od_i2c_pin_decode u_pins (
    .st(st_d), .hi(hi_d), .bitn(bitn_d), .msb(sh_d[7]),
    .scl(scl_d), .oe(oe_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; stage <= PH_ADDR_W; hi <= 1'b0; bitn <= '0; sh <= '0;
      reg_q <= '0; wdata_q <= '0; is_rd <= 1'b0;
      scl_o <= 1'b1; sda_oe <= 1'b0; done <= 1'b0; rd_data <= '0;
      err_nack <= 1'b0; err_phase <= '0; err_stuck <= 1'b0;
    end else begin
      st <= st_d; stage <= stage_d; hi <= hi_d; bitn <= bitn_d; sh <= sh_d;
      scl_o <= scl_d; sda_oe <= oe_d;
      done <= fin;
      if (accept) begin
        reg_q <= req_reg; wdata_q <= req_wdata; is_rd <= req_op[1];
        err_nack <= 1'b0; err_phase <= '0; err_stuck <= 1'b0;
      end
      if (fin) begin
        err_nack  <= nk;
        err_phase <= nk ? stage : PH_ADDR_W;
        err_stuck <= stk;
        if (is_rd && !nk) rd_data <= sh;
      end
    end
  end

  // R1: idle means both lines released
  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (scl_o && !sda_oe));
  // R2: accepted request blocks the port
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  // R3: pins move only after a slot boundary or an accept
  p_pin_grid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({scl_o, sda_oe}) |-> $past(tick || accept));
  // R5: data bit held while clock is high
  p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WB && hi) |-> $stable(sda_oe));
  // R11: read register only moves at completion
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> done);
  // R12: completion is a single pulse
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/od_i2c_reg_master_tb.sv
`timescale 1ns/1ps
module od_i2c_reg_master_tb;
  localparam int HALF = 5;
  localparam logic [6:0] ADDR = 7'h67;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, req_valid, req_ready, done, err_nack, err_stuck, scl_o, sda_oe;
  logic [1:0] req_op, err_phase;
  logic [7:0] req_reg, req_wdata, rd_data;
  logic tgt_pull;
  wire  sda_line = !(sda_oe || tgt_pull);

  od_i2c_reg_master #(.HALF_CYCLES(HALF), .TARGET_ADDR(ADDR)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_reg(req_reg), .req_wdata(req_wdata), .done(done),
    .rd_data(rd_data), .err_nack(err_nack), .err_phase(err_phase),
    .err_stuck(err_stuck), .scl_o(scl_o), .sda_oe(sda_oe), .sda_i(sda_line)
  );

  int n_cmp = 0, n_bad = 0;
  bit q_scl[$], q_oe[$], q_pull[$];
  string q_tag[$];
  logic [7:0] exp_rd = 8'h00;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic slot(bit s, bit o, bit p, string t);
    q_scl.push_back(s); q_oe.push_back(o); q_pull.push_back(p); q_tag.push_back(t);
  endtask

  task automatic seq_start();
    slot(1, 0, 0, "R4"); slot(1, 1, 0, "R4");
  endtask
  task automatic seq_stop();
    slot(0, 1, 0, "R4"); slot(1, 1, 0, "R4"); slot(1, 0, 0, "R4");
  endtask
  task automatic seq_wbyte(logic [7:0] b, bit ack);
    for (int i = 7; i >= 0; i--) begin
      slot(0, !b[i], 0, "R5"); slot(1, !b[i], 0, "R5");
    end
    slot(0, 0, ack, "R6"); slot(1, 0, ack, "R6");
  endtask
  task automatic seq_rbyte(logic [7:0] d);
    slot(0, 0, 0, "R8");
    for (int i = 7; i >= 0; i--) begin
      slot(0, 0, !d[i], "R8"); slot(1, 0, !d[i], "R8");
    end
    slot(0, 0, 0, "R8"); slot(1, 0, 0, "R8");
  endtask

  // op: 0 init, 1 write, 2 read; nack_at: -1 none, else failing byte code
  task automatic run(int op, logic [7:0] rg, logic [7:0] wd, int nack_at,
                     logic [7:0] rdat, int stuck, bit junk);
    bit alive;
    string rtag;
    q_scl.delete(); q_oe.delete(); q_pull.delete(); q_tag.delete();
    alive = 1;
    if (op == 0) begin
      slot(1, 0, stuck > 0, "R10"); slot(1, 0, stuck > 0, "R10");
      if (stuck > 0)
        for (int k = 0; k < 8; k++) begin
          slot(0, 0, stuck == 2, "R10"); slot(1, 0, stuck == 2, "R10");
        end
    end else begin
      seq_start();
      seq_wbyte({ADDR, 1'b0}, nack_at != 0);
      alive = (nack_at != 0);
      if (alive) begin seq_wbyte(rg, nack_at != 1); alive = (nack_at != 1); end
      if (alive && op == 1) begin
        seq_wbyte(wd, nack_at != 2); alive = (nack_at != 2);
        if (alive) seq_stop();
      end else if (alive) begin
        seq_stop(); seq_start();
        seq_wbyte({ADDR, 1'b1}, nack_at != 3); alive = (nack_at != 3);
        if (alive) begin seq_rbyte(rdat); seq_stop(); end
      end
    end
    if (op == 2 && nack_at < 0) exp_rd = rdat;
    rtag = (op == 1) ? "R7" : (op == 2) ? "R8" : "R10";

    @(negedge clk);
    req_valid = 1; req_op = 2'(op); req_reg = rg; req_wdata = wd; tgt_pull = 0;
    @(posedge clk);
    for (int i = 0; i < q_scl.size(); i++) begin
      for (int c = 0; c < HALF; c++) begin
        @(negedge clk);
        if (i == 0 && c == 0) begin
          if (junk) begin req_op = ~req_op; req_reg = ~req_reg; end
          else req_valid = 0;
        end
        if (i == 2 && c == 0) req_valid = 0;
        tgt_pull = q_pull[i];
        #1;
        chk(scl_o == q_scl[i], {"R3/", q_tag[i]}, "scl_o", scl_o, q_scl[i]);
        chk(sda_oe == q_oe[i], {"R3/", q_tag[i]}, "sda_oe", sda_oe, q_oe[i]);
        chk(!req_ready, "R2", "req_ready busy", req_ready, 0);
        chk(!done, "R12", "done early", done, 0);
      end
      @(posedge clk);
    end
    @(negedge clk);
    tgt_pull = 0;
    #1;
    chk(done, "R12", "done pulse", done, 1);
    chk(req_ready, "R2", "req_ready after", req_ready, 1);
    chk(scl_o && !sda_oe, "R1", "idle lines", {scl_o, sda_oe}, 2'b10);
    chk(err_nack == (nack_at >= 0), (nack_at >= 0) ? "R9" : rtag, "err_nack",
        err_nack, nack_at >= 0);
    chk(err_phase == ((nack_at >= 0) ? 2'(nack_at) : 2'd0), "R9", "err_phase",
        err_phase, (nack_at >= 0) ? nack_at : 0);
    chk(err_stuck == (stuck == 2), "R10", "err_stuck", err_stuck, stuck == 2);
    chk(rd_data == exp_rd, "R8/R11", "rd_data", rd_data, exp_rd);
    @(negedge clk);
    chk(!done, "R12", "done single", done, 0);
    chk(err_nack == (nack_at >= 0), "R12", "err_nack held", err_nack, nack_at >= 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; req_valid = 0; req_op = 0; req_reg = 0; req_wdata = 0; tgt_pull = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    chk(scl_o && !sda_oe, "R1", "reset lines", {scl_o, sda_oe}, 2'b10);
    chk(req_ready && !done, "R1", "reset ready/done", {req_ready, done}, 2'b10);
    chk(rd_data == 0 && !err_nack && !err_stuck && err_phase == 0, "R1",
        "reset flags", {rd_data, err_nack, err_stuck, err_phase}, 0);

    run(0, 8'h00, 8'h00, -1, 8'h00, 0, 0);   // R10 clean bus
    run(0, 8'h00, 8'h00, -1, 8'h00, 1, 0);   // R10 recovered
    run(0, 8'h00, 8'h00, -1, 8'h00, 2, 0);   // R10 stuck
    run(1, 8'h17, 8'hA5, -1, 8'h00, 0, 0);   // R7
    run(1, 8'h00, 8'hFF, -1, 8'h00, 0, 1);   // R7 + R2 junk while busy
    run(2, 8'h17, 8'h00, -1, 8'h5A, 0, 0);   // R8
    run(1, 8'h18, 8'h33, 0, 8'h00, 0, 0);    // R9 address phase, R11
    run(1, 8'h18, 8'h33, 1, 8'h00, 0, 0);    // R9 register phase
    run(1, 8'h18, 8'h33, 2, 8'h00, 0, 0);    // R9 value phase
    run(2, 8'h1A, 8'h00, 3, 8'hC3, 0, 0);    // R9 read address, R11
    run(2, 8'h1A, 8'h00, 1, 8'hC3, 0, 1);    // R9 register in read
    run(2, 8'h07, 8'h00, -1, 8'h00, 0, 0);   // R8 zeros
    run(2, 8'hFF, 8'h00, -1, 8'hFF, 0, 0);   // R8 ones
    run(1, 8'h11, 8'h01, -1, 8'h00, 0, 0);   // R11 write keeps rd_data

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule